// File: doc/BRIEF.md
# Snooping Write-Through Cache Controller

This block is a direct-mapped cache for one processor on a shared memory bus. Each line holds a valid bit, a tag and one data word. A processor read that hits is answered from the line. A read that misses fetches the word over the bus, returns it to the processor and fills the line. Every processor write goes out to main memory over the bus. When the write address is already cached, the local line is updated in the same step. A write that misses allocates nothing.

Other bus agents, DMA engines and I/O processors among them, may change memory behind the cache. A snoop input reports every bus write together with the identifier of the agent that made it. When a foreign write lands on an address that a valid line holds, that line is invalidated, so the next processor read of it goes to memory. Snooped writes that carry this controller's own identifier are echoes of its own traffic and are ignored.

The processor request port and the bus request port are valid/ready channels. A transfer happens on a cycle where both valid and ready are high. While valid is high and ready is low, the sender holds every field stable. The processor read response is also valid/ready, and its data stays stable until it is accepted. At most one bus transaction is outstanding. The processor request ready is low from the acceptance of a request until that request is done: for a read, until its response is accepted; for a write, until the bus accepts the write.

Top module: `snc_cache_top`

## Requirements
- R1: After reset all lines are invalid, cpu_req_ready is 1, and bus_req_valid and cpu_rsp_valid are 0. The first read of any address after reset issues a bus read.
- R2: A read of an address held by a valid line returns that line's word. It issues no bus read, and cpu_rsp_valid rises in the cycle after the request is accepted.
- R3: A read miss issues one bus read (bus_req_we=0) to the request address. The returned word goes to the processor and fills the line, so a repeat read of the address hits.
- R4: Every accepted write issues one bus write (bus_req_we=1) with the same address and data. On a hit the line takes the new word, and a later read returns it without a bus read. A miss leaves the cache unchanged, so a later read of that address misses.
- R5: A snoop with snp_valid=1, an snp_id different from MASTER_ID and an address held by a valid line invalidates that line. The next read of the address fetches the new word from the bus.
- R6: A snoop whose snp_id equals MASTER_ID has no effect on the cache.
- R7: A foreign snoop changes nothing when its tag differs from that of the line at its index.
- R8: A foreign snoop that arrives in the same cycle as a line fill or a write-hit update of the same index wins when the tags are equal, and the line ends invalid. When the tags differ, the fill completes and the line ends valid with the new tag.
- R9: At most one transaction is in flight. cpu_req_ready stays 0 from the acceptance of a request until it completes, and it is 0 whenever bus_req_valid is 1.
- R10: While bus_req_valid=1 and bus_req_ready=0, the bus request fields do not change. While cpu_rsp_valid=1 and cpu_rsp_ready=0, the response stays valid with unchanged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address; low INDEX_W bits select the line, the rest are the tag |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Read response valid |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | DATA_W | Read data |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_req_addr | output | ADDR_W | Bus word address |
| bus_req_wdata | output | DATA_W | Bus write data |
| bus_req_id | output | ID_W | This controller's agent identifier (MASTER_ID) |
| bus_rsp_valid | input | 1 | Bus read data valid, one cycle |
| bus_rsp_rdata | input | DATA_W | Bus read data |
| snp_valid | input | 1 | A bus write was observed |
| snp_addr | input | ADDR_W | Address of the observed write |
| snp_id | input | ID_W | Identifier of the agent that wrote |

## Verification
On every cycle the assertions check five things. A foreign snoop that hits a line leaves it invalid in the next cycle, and a fill that races a snoop of equal tag ends invalid. Any other fill leaves its line valid with the new tag. An accepted write always turns into a matching bus write, and a read miss into a matching bus read. Ready stays low while the bus is busy, and both valid/ready channels hold their contents under back-pressure. The bench scenarios are needed for the rest: that returned data equals memory contents across hit and miss sequences, that a write miss does not allocate, that an echo snoop and a snoop of another tag leave a hit in place, and that after a same-cycle race the next read misses or hits as required.

// File: rtl/snc_pkg.sv
package snc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUS_RD,
    ST_WAIT_RD,
    ST_BUS_WR,
    ST_RSP
  } snc_state_e;
endpackage

// File: rtl/snc_snoop_filter.sv
module snc_snoop_filter #(
  parameter int ADDR_W    = 16,
  parameter int INDEX_W   = 3,
  parameter int ID_W      = 2,
  parameter int MASTER_ID = 1
) (
  input  logic                      snp_valid,
  input  logic [ADDR_W-1:0]         snp_addr,
  input  logic [ID_W-1:0]           snp_id,
  output logic                      sn_en,
  output logic [INDEX_W-1:0]        sn_idx,
  output logic [ADDR_W-INDEX_W-1:0] sn_tag
);
  // only writes by other agents can make a local copy stale
  assign sn_en  = snp_valid && (snp_id != ID_W'(MASTER_ID));
  assign sn_idx = snp_addr[INDEX_W-1:0];
  assign sn_tag = snp_addr[ADDR_W-1:INDEX_W];
endmodule

// File: rtl/snc_line_store.sv
module snc_line_store #(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 13,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] lk_idx,
  output logic               lk_valid,
  output logic [TAG_W-1:0]   lk_tag,
  output logic [DATA_W-1:0]  lk_data,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               sn_en,
  input  logic [INDEX_W-1:0] sn_idx,
  input  logic [TAG_W-1:0]   sn_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0]             valid_all;
  logic [LINES-1:0][TAG_W-1:0]  tag_all;
  logic [LINES-1:0][DATA_W-1:0] data_all;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              valid_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;
    logic              wr_here, sn_here;

    assign wr_here = wr_en && (wr_idx == INDEX_W'(i));
    assign sn_here = sn_en && (sn_idx == INDEX_W'(i));

    // the invalidate outranks a write only when it targets the same tag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_r <= 1'b0;
      end else if (wr_here) begin
        valid_r <= !(sn_here && (sn_tag == wr_tag));
      end else if (sn_here && (tag_r == sn_tag)) begin
        valid_r <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        tag_r  <= wr_tag;
        data_r <= wr_data;
      end
    end

    assign valid_all[i] = valid_r;
    assign tag_all[i]   = tag_r;
    assign data_all[i]  = data_r;
  end

  assign lk_valid = valid_all[lk_idx];
  assign lk_tag   = tag_all[lk_idx];
  assign lk_data  = data_all[lk_idx];

  logic sn_hit;
  assign sn_hit = valid_all[sn_idx] && (tag_all[sn_idx] == sn_tag);

  assert_snoop_invalidates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_en && sn_hit && !(wr_en && (wr_idx == sn_idx) && (wr_tag != sn_tag)))
    |=> !valid_all[$past(sn_idx)]);

  assert_race_same_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sn_en && (wr_idx == sn_idx) && (wr_tag == sn_tag))
    |=> !valid_all[$past(wr_idx)]);

  assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(sn_en && (sn_idx == wr_idx) && (sn_tag == wr_tag)))
    |=> (valid_all[$past(wr_idx)] && (tag_all[$past(wr_idx)] == $past(wr_tag))));
endmodule

// File: rtl/snc_ctrl.sv
module snc_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req_valid,
  output logic                      cpu_req_ready,
  input  logic                      cpu_req_we,
  input  logic [ADDR_W-1:0]         cpu_req_addr,
  input  logic [DATA_W-1:0]         cpu_req_wdata,
  output logic                      cpu_rsp_valid,
  input  logic                      cpu_rsp_ready,
  output logic [DATA_W-1:0]         cpu_rsp_rdata,
  output logic [INDEX_W-1:0]        lk_idx,
  input  logic                      lk_valid,
  input  logic [ADDR_W-INDEX_W-1:0] lk_tag,
  input  logic [DATA_W-1:0]         lk_data,
  output logic                      wr_en,
  output logic [INDEX_W-1:0]        wr_idx,
  output logic [ADDR_W-INDEX_W-1:0] wr_tag,
  output logic [DATA_W-1:0]         wr_data,
  output logic                      bus_req_valid,
  input  logic                      bus_req_ready,
  output logic                      bus_req_we,
  output logic [ADDR_W-1:0]         bus_req_addr,
  output logic [DATA_W-1:0]         bus_req_wdata,
  input  logic                      bus_rsp_valid,
  input  logic [DATA_W-1:0]         bus_rsp_rdata
);
  snc_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept, hit, fill, upd;

  assign cpu_req_ready = (st_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign lk_idx        = cpu_req_addr[INDEX_W-1:0];
  assign hit           = lk_valid && (lk_tag == cpu_req_addr[ADDR_W-1:INDEX_W]);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        if (cpu_req_we)  st_d = ST_BUS_WR;
        else if (hit)    st_d = ST_RSP;
        else             st_d = ST_BUS_RD;
      end
      ST_BUS_RD:  if (bus_req_ready) st_d = ST_WAIT_RD;
      ST_WAIT_RD: if (bus_rsp_valid) st_d = ST_RSP;
      ST_BUS_WR:  if (bus_req_ready) st_d = ST_IDLE;
      ST_RSP:     if (cpu_rsp_ready) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // data_q carries write data to the bus, or read data to the processor
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= cpu_req_addr;
      data_q <= cpu_req_we ? cpu_req_wdata : lk_data;
    end else if (fill) begin
      data_q <= bus_rsp_rdata;
    end
  end

  assign fill    = (st_q == ST_WAIT_RD) && bus_rsp_valid;
  assign upd     = accept && cpu_req_we && hit;
  assign wr_en   = fill || upd;
  assign wr_idx  = fill ? addr_q[INDEX_W-1:0]      : cpu_req_addr[INDEX_W-1:0];
  assign wr_tag  = fill ? addr_q[ADDR_W-1:INDEX_W] : cpu_req_addr[ADDR_W-1:INDEX_W];
  assign wr_data = fill ? bus_rsp_rdata            : cpu_req_wdata;

  assign bus_req_valid = (st_q == ST_BUS_RD) || (st_q == ST_BUS_WR);
  assign bus_req_we    = (st_q == ST_BUS_WR);
  assign bus_req_addr  = addr_q;
  assign bus_req_wdata = data_q;
  assign cpu_rsp_valid = (st_q == ST_RSP);
  assign cpu_rsp_rdata = data_q;

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready);

  assert_write_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && cpu_req_we)
    |=> (bus_req_valid && bus_req_we && (bus_req_addr == $past(cpu_req_addr))
         && (bus_req_wdata == $past(cpu_req_wdata))));

  assert_miss_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && !cpu_req_we && !hit)
    |=> (bus_req_valid && !bus_req_we && (bus_req_addr == $past(cpu_req_addr))));

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready)
    |=> (bus_req_valid && $stable(bus_req_we) && $stable(bus_req_addr) && $stable(bus_req_wdata)));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));
endmodule

// File: rtl/snc_cache_top.sv
module snc_cache_top #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int INDEX_W   = 3,
  parameter int ID_W      = 2,
  parameter int MASTER_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_we,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  output logic [ID_W-1:0]   bus_req_id,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [INDEX_W-1:0] lk_idx, wr_idx, sn_idx;
  logic               lk_valid, wr_en, sn_en;
  logic [TAG_W-1:0]   lk_tag, wr_tag, sn_tag;
  logic [DATA_W-1:0]  lk_data, wr_data;

  assign bus_req_id = ID_W'(MASTER_ID);

  snc_snoop_filter #(
    .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .ID_W(ID_W), .MASTER_ID(MASTER_ID)
  ) u_filter (
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_id(snp_id),
    .sn_en(sn_en), .sn_idx(sn_idx), .sn_tag(sn_tag)
  );

  snc_line_store #(
    .INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .sn_en(sn_en), .sn_idx(sn_idx), .sn_tag(sn_tag)
  );

  snc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_req_we(bus_req_we),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata)
  );
endmodule

// File: tb/tb_snc_cache_top.sv
module tb_snc_cache_top;
  localparam int AW = 16, DW = 32, IW = 3, IDW = 2;
  localparam logic [IDW-1:0] OWN_ID = 2'd1, DMA_ID = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cpu_req_valid = 0, cpu_req_we = 0, cpu_rsp_ready = 1;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid, bus_req_valid, bus_req_we;
  logic [DW-1:0] cpu_rsp_rdata, bus_req_wdata;
  logic [AW-1:0] bus_req_addr;
  logic [IDW-1:0] bus_req_id;
  logic bus_req_ready, bus_rsp_valid, snp_valid;
  logic [DW-1:0] bus_rsp_rdata;
  logic [AW-1:0] snp_addr;
  logic [IDW-1:0] snp_id;

  snc_cache_top #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW), .ID_W(IDW), .MASTER_ID(1)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_req_we(bus_req_we),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata), .bus_req_id(bus_req_id),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_id(snp_id)
  );

  // memory and bus agent; the only writer of mem and bus counters
  logic [DW-1:0] mem [0:255];
  int bus_rd_cnt = 0, bus_wr_cnt = 0;
  int sn_seq = 0, sn_done = 0, inj_seq = 0, inj_done = 0;
  logic [AW-1:0] sn_a, inj_a;
  logic [DW-1:0] sn_d, inj_d;
  logic [IDW-1:0] sn_i;
  bit stall_mode = 0;

  initial begin
    logic rd_pend;
    int rd_wait;
    logic [AW-1:0] rd_a;
    rd_pend = 0; rd_wait = 0; rd_a = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + i * 32'h0101;
    bus_req_ready = 0; bus_rsp_valid = 0; bus_rsp_rdata = '0;
    snp_valid = 0; snp_addr = '0; snp_id = '0;
    forever begin
      @(negedge clk);
      bus_rsp_valid = 0;
      snp_valid = 0;
      if (rd_pend) begin
        if (rd_wait == 0) begin
          bus_rsp_valid = 1;
          bus_rsp_rdata = mem[rd_a[7:0]];
          rd_pend = 0;
          if (inj_seq != inj_done) begin
            snp_valid = 1; snp_addr = inj_a; snp_id = DMA_ID;
            mem[inj_a[7:0]] = inj_d;
            inj_done = inj_seq;
          end
        end else rd_wait--;
      end else if (sn_seq != sn_done) begin
        snp_valid = 1; snp_addr = sn_a; snp_id = sn_i;
        if (sn_i != OWN_ID) mem[sn_a[7:0]] = sn_d;
        sn_done = sn_seq;
      end
      bus_req_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;
      if (bus_req_valid && bus_req_ready) begin
        if (bus_req_we) begin
          mem[bus_req_addr[7:0]] = bus_req_wdata;
          bus_wr_cnt++;
        end else begin
          rd_pend = 1; rd_a = bus_req_addr;
          rd_wait = stall_mode ? int'($urandom % 3) : 0;
          bus_rd_cnt++;
        end
      end
    end
  end

  int checks = 0, failures = 0;
  bit done = 0;
  bit mv [8];
  logic [AW-IW-1:0] mt [8];

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a);
    return mv[a[IW-1:0]] && (mt[a[IW-1:0]] == a[AW-1:IW]);
  endfunction

  task automatic do_read(input logic [AW-1:0] a, input string req);
    logic [DW-1:0] exp_d;
    bit exp_hit;
    int c0, n;
    exp_d = mem[a[7:0]];
    exp_hit = model_hit(a);
    c0 = bus_rd_cnt;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = 0; cpu_req_addr = a;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 0;
    check(cpu_req_ready == 0, "R9 ready low after read accept", 32'(cpu_req_ready), 0);
    n = 0;
    while (!cpu_rsp_valid && n < 60) begin @(negedge clk); n++; end
    check(cpu_rsp_valid && cpu_rsp_rdata == exp_d, {req, " read data"}, cpu_rsp_rdata, exp_d);
    check((bus_rd_cnt != c0) == !exp_hit, exp_hit ? "R2 hit without bus read" : "R3 miss issues bus read",
          32'(bus_rd_cnt - c0), exp_hit ? 0 : 1);
    if (exp_hit) check(n == 0, "R2 hit response next cycle", 32'(n), 0);
    if (!exp_hit) begin mv[a[IW-1:0]] = 1; mt[a[IW-1:0]] = a[AW-1:IW]; end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w0, n;
    w0 = bus_wr_cnt;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = 1; cpu_req_addr = a; cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 0; cpu_req_we = 0;
    check(cpu_req_ready == 0, "R9 ready low during bus write", 32'(cpu_req_ready), 0);
    n = 0;
    while (!cpu_req_ready && n < 60) begin @(negedge clk); n++; end
    check(bus_wr_cnt == w0 + 1, "R4 one bus write", 32'(bus_wr_cnt - w0), 1);
    check(mem[a[7:0]] == d, "R4 memory updated", mem[a[7:0]], d);
  endtask

  task automatic do_snoop(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [IDW-1:0] id);
    sn_a = a; sn_d = d; sn_i = id;
    sn_seq++;
    while (sn_done != sn_seq) @(negedge clk);
    @(negedge clk);
    if (id != OWN_ID && model_hit(a)) mv[a[IW-1:0]] = 0;
  endtask

  initial begin
    logic [DW-1:0] held;
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mt[i] = '0; end
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cpu_req_ready == 1, "R1 ready after reset", 32'(cpu_req_ready), 1);
    check(bus_req_valid == 0, "R1 no bus request after reset", 32'(bus_req_valid), 0);
    check(cpu_rsp_valid == 0, "R1 no response after reset", 32'(cpu_rsp_valid), 0);

    do_read(16'h0005, "R1 first read misses");
    do_read(16'h0005, "R2");
    do_write(16'h0005, 32'hCAFE_0005);          // write hit
    do_read(16'h0005, "R4 write hit visible");
    do_write(16'h000D, 32'hBEEF_000D);          // write miss, same index
    do_read(16'h000D, "R4 write miss no allocate");
    do_snoop(16'h000D, 32'hD0D0_000D, DMA_ID);
    do_read(16'h000D, "R5 snoop invalidates");
    do_snoop(16'h000D, 32'h5555_5555, OWN_ID);
    do_read(16'h000D, "R6 own snoop ignored");
    do_snoop(16'h0015, 32'h7777_0015, DMA_ID);
    do_read(16'h000D, "R7 other tag keeps line");
    do_snoop(16'h000E, 32'h7777_000E, DMA_ID);
    do_read(16'h000D, "R7 other index keeps line");

    // R8: snoop of equal tag in the fill cycle
    inj_a = 16'h0021; inj_d = 32'hABCD_0021; inj_seq++;
    do_read(16'h0021, "R8 race same tag");
    check(inj_done == inj_seq, "R8 inject happened", 32'(inj_done), 32'(inj_seq));
    mv[1] = 0;
    do_read(16'h0021, "R8 same tag line invalid");
    // R8: snoop of a different tag in the fill cycle
    inj_a = 16'h0032; inj_d = 32'hABCD_0032; inj_seq++;
    do_read(16'h002A, "R8 race other tag");
    do_read(16'h002A, "R8 other tag fill kept");

    // R10: response held under back-pressure
    cpu_rsp_ready = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = 0; cpu_req_addr = 16'h002A;
    @(negedge clk);
    cpu_req_valid = 0;
    held = cpu_rsp_rdata;
    repeat (3) @(negedge clk);
    check(cpu_rsp_valid && cpu_rsp_rdata == held && held == mem[8'h2A], "R10 response held",
          cpu_rsp_rdata, mem[8'h2A]);
    cpu_rsp_ready = 1;
    @(negedge clk);

    // constrained random phase with bus stalls and latency
    stall_mode = 1;
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      int op;
      a = AW'($urandom % 64);
      op = int'($urandom % 20);
      if (op < 10)      do_read(a, "R3 random read");
      else if (op < 15) do_write(a, $urandom);
      else if (op < 19) do_snoop(a, $urandom, DMA_ID);
      else              do_snoop(a, $urandom, OWN_ID);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end
endmodule